// File: doc/BRIEF.md
# Trace capture circular buffer

This block is a trace sink. It writes a stream of 32-bit trace words into an internal RAM that acts as a ring. Software reaches it through a zero-wait-state APB-style register port. Through that port it loads the ring pointers, sets a post-trigger word budget and starts or stops capture. It can also request a manual flush and read the stored words back.

While capture runs, every valid trace word goes into the slot at the write pointer. The pointer then moves on and wraps at the RAM depth. A wrap sets a sticky full flag, which tells software that older words were overwritten.

Capture can end in three ways:
- the post-trigger budget runs out after a trigger;
- a manual flush completes while stop-on-flush is set;
- software clears the enable bit.

In every case the block first pads the current 4-word frame with zero words. Only then does it raise the stopped status. Pointer loads and direct data writes by software take effect only while capture is stopped.

Top module: `trace_ring_top`

## Requirements
- R1: After reset the write pointer, read pointer, trigger count, control word and full flag read 0. Formatter status (0x300) reads 0x2, meaning bit 1 is stopped. The depth register (0x004) reads the RAM size in words, with bit 31 at 0.
- R2: While stopped, each write to the write-data register (0x024) stores the word at the write pointer and then advances it. Each read of the read-data register (0x010) returns the word at the read pointer and then advances it. Both pointers wrap from DEPTH-1 to 0.
- R3: Writes to the read pointer (0x014) and write pointer (0x018) load them directly while stopped. While capture is running or padding, these writes and data-register writes are ignored.
- R4: While running, each cycle with trc_valid high stores trc_data at the write pointer and then advances the pointer.
- R5: Status bit 0 (0x00C) is set when the write pointer wraps from DEPTH-1 to 0. It is cleared only by writing 0 to the write pointer.
- R6: When formatter-control bit 13 is set, a trig_in pulse while running arms the trigger. Each word stored in a later cycle decrements the trigger count (0x01C). When the count reaches 0, capture stops. With bit 13 clear, trig_in has no effect.
- R7: Before the stopped status rises, the write pointer is padded with zero words up to a multiple of 4. Trace words offered while padding or stopped are dropped.
- R8: Writing 1 to formatter-control bit 6 starts a flush, and the bit reads 1 until the flush completes. The flush completes once the frame is padded to a 4-word boundary, or at once when stopped. If bit 12 is set, capture then stops. If bit 12 is clear, capture goes on.
- R9: Writing 0 to control bit 0 (0x020) ends capture through padding. Writing 1 while stopped restarts capture and disarms the trigger.
- R10: Formatter-control bits 0, 12 and 13 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Register byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger pulse |

## Verification
The embedded assertions check these rules on every cycle:
- the write pointer is frame-aligned whenever the stopped state rises;
- the full flag never clears without a zero write to the write pointer;
- a pending flush clears one cycle after it is seen in the stopped state;
- pad slots carry zeros;
- the write pointer holds still while stopped;
- the trigger count never grows on its own during capture.

Only the directed scenarios can show the rest:
- how many words land after a trigger;
- the exact pointer values after padding;
- the contents read back through the data register;
- that software writes are dropped during capture.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
    localparam int FRAME_LOG2 = 2;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_PAD  = 2'd2
    } cap_state_e;

    localparam logic [11:0] A_SIZE = 12'h004;
    localparam logic [11:0] A_STAT = 12'h00C;
    localparam logic [11:0] A_RDAT = 12'h010;
    localparam logic [11:0] A_RPTR = 12'h014;
    localparam logic [11:0] A_WPTR = 12'h018;
    localparam logic [11:0] A_TCNT = 12'h01C;
    localparam logic [11:0] A_CTRL = 12'h020;
    localparam logic [11:0] A_WDAT = 12'h024;
    localparam logic [11:0] A_FSTS = 12'h300;
    localparam logic [11:0] A_FCTL = 12'h304;
endpackage

// File: rtl/trace_ring_ram.sv
module trace_ring_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/trace_ring_ctrl.sv
module trace_ring_ctrl
    import trace_ring_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr_ctrl,
    input  logic          sw_wr_fmt,
    input  logic          sw_wr_wptr,
    input  logic          sw_wr_rptr,
    input  logic          sw_wr_trg,
    input  logic          sw_wr_data,
    input  logic          sw_rd_data,
    input  logic [DW-1:0] sw_wdata,
    input  logic          trc_valid,
    input  logic [DW-1:0] trc_data,
    input  logic          trig,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          full,
    output logic          stopped,
    output logic          capt_en,
    output logic          fmt_en,
    output logic          stop_on_flush,
    output logic          stop_on_trig,
    output logic          flush_busy,
    output logic [DW-1:0] trg_cnt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    typedef struct packed {
        cap_state_e    st;
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic          full;
        logic          capt_en;
        logic          fmt_en;
        logic          stop_fl;
        logic          stop_tr;
        logic          flush;
        logic          armed;
        logic [DW-1:0] cnt;
    } regs_t;

    regs_t q, d;
    logic  halt;
    logic  do_store;
    logic [DW-1:0] st_data;

    always_comb begin
        d        = q;
        do_store = 1'b0;
        st_data  = '0;
        halt     = (q.armed && (q.cnt == '0)) || !q.capt_en || (q.flush && q.stop_fl);

        unique case (q.st)
            ST_STOP: begin
                d.flush = 1'b0;
                if (sw_wr_data) begin
                    do_store = 1'b1;
                    st_data  = sw_wdata;
                end
                if (sw_wr_ctrl && sw_wdata[0]) begin
                    d.st    = ST_RUN;
                    d.armed = 1'b0;
                end
            end
            ST_RUN: begin
                if (halt || q.flush) begin
                    d.st = ST_PAD;
                end else begin
                    if (trc_valid) begin
                        do_store = 1'b1;
                        st_data  = trc_data;
                        if (q.armed) d.cnt = q.cnt - 1'b1;
                    end
                    if (trig && q.stop_tr && !q.armed) d.armed = 1'b1;
                end
            end
            ST_PAD: begin
                if (q.wptr[FRAME_LOG2-1:0] != '0) begin
                    do_store = 1'b1;
                end else begin
                    d.flush = 1'b0;
                    d.st    = halt ? ST_STOP : ST_RUN;
                end
            end
            default: d.st = ST_STOP;
        endcase

        if (do_store) begin
            d.wptr = q.wptr + 1'b1;
            if (q.wptr == '1) d.full = 1'b1;
        end
        if (q.st == ST_STOP) begin
            if (sw_wr_wptr) begin
                d.wptr = sw_wdata[AW-1:0];
                if (sw_wdata[AW-1:0] == '0) d.full = 1'b0;
            end
            if (sw_wr_rptr) d.rptr = sw_wdata[AW-1:0];
        end
        if (sw_rd_data) d.rptr = q.rptr + 1'b1;
        if (sw_wr_ctrl) d.capt_en = sw_wdata[0];
        if (sw_wr_fmt) begin
            d.fmt_en  = sw_wdata[0];
            d.stop_fl = sw_wdata[12];
            d.stop_tr = sw_wdata[13];
            if (sw_wdata[6]) d.flush = 1'b1;
        end
        if (sw_wr_trg) d.cnt = sw_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_STOP;
        end else begin
            q <= d;
        end
    end

    assign wptr          = q.wptr;
    assign rptr          = q.rptr;
    assign full          = q.full;
    assign stopped       = (q.st == ST_STOP);
    assign capt_en       = q.capt_en;
    assign fmt_en        = q.fmt_en;
    assign stop_on_flush = q.stop_fl;
    assign stop_on_trig  = q.stop_tr;
    assign flush_busy    = q.flush;
    assign trg_cnt       = q.cnt;
    assign mem_we        = do_store;
    assign mem_addr      = q.wptr;
    assign mem_wdata     = st_data;

    // R7
    stop_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_STOP) |-> (q.wptr[FRAME_LOG2-1:0] == '0));

    // R7
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PAD && mem_we) |-> (mem_wdata == '0));

    // R5
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.full) |-> $past(sw_wr_wptr && (sw_wdata[AW-1:0] == '0)));

    // R8
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flush && q.st == ST_STOP && !sw_wr_fmt) |=> !q.flush);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STOP && !sw_wr_data && !sw_wr_wptr) |=> $stable(q.wptr));

    // R6
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_STOP && !sw_wr_trg) |=> (q.cnt <= $past(q.cnt)));
endmodule

// File: rtl/trace_ring_top.sv
module trace_ring_top
    import trace_ring_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    input  logic        trc_valid,
    input  logic [31:0] trc_data,
    input  logic        trig_in
);
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;

    logic          acc_wr, acc_rd;
    logic [AW-1:0] wptr, rptr, mem_addr;
    logic          full, stopped, capt_en, fmt_en, stop_fl, stop_tr, flush_busy, mem_we;
    logic [DW-1:0] trg_cnt, mem_wdata, mem_rdata;

    assign acc_wr = psel && penable && pwrite;
    assign acc_rd = psel && penable && !pwrite;

    trace_ring_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_wr_ctrl    (acc_wr && paddr == A_CTRL),
        .sw_wr_fmt     (acc_wr && paddr == A_FCTL),
        .sw_wr_wptr    (acc_wr && paddr == A_WPTR),
        .sw_wr_rptr    (acc_wr && paddr == A_RPTR),
        .sw_wr_trg     (acc_wr && paddr == A_TCNT),
        .sw_wr_data    (acc_wr && paddr == A_WDAT),
        .sw_rd_data    (acc_rd && paddr == A_RDAT),
        .sw_wdata      (pwdata),
        .trc_valid     (trc_valid),
        .trc_data      (trc_data),
        .trig          (trig_in),
        .wptr          (wptr),
        .rptr          (rptr),
        .full          (full),
        .stopped       (stopped),
        .capt_en       (capt_en),
        .fmt_en        (fmt_en),
        .stop_on_flush (stop_fl),
        .stop_on_trig  (stop_tr),
        .flush_busy    (flush_busy),
        .trg_cnt       (trg_cnt),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata)
    );

    trace_ring_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rptr),
        .rdata (mem_rdata)
    );

    always_comb begin
        prdata = '0;
        if (acc_rd) begin
            unique case (paddr)
                A_SIZE:  prdata = DW'(DEPTH) & 32'h7FFF_FFFF;
                A_STAT:  prdata = {31'b0, full};
                A_RDAT:  prdata = mem_rdata;
                A_RPTR:  prdata = DW'(rptr);
                A_WPTR:  prdata = DW'(wptr);
                A_TCNT:  prdata = trg_cnt;
                A_CTRL:  prdata = {31'b0, capt_en};
                A_FSTS:  prdata = {30'b0, stopped, 1'b0};
                A_FCTL:  prdata = {18'b0, stop_tr, stop_fl, 5'b0, flush_busy, 5'b0, fmt_en};
                default: prdata = '0;
            endcase
        end
    end
endmodule

// File: tb/sim_trace_ring_top.sv
`timescale 1ns/1ps
module sim_trace_ring_top;
    localparam logic [11:0] SIZE = 12'h004, STAT = 12'h00C, RDAT = 12'h010, RPTR = 12'h014,
                            WPTR = 12'h018, TCNT = 12'h01C, CTRL = 12'h020, WDAT = 12'h024,
                            FSTS = 12'h300, FCTL = 12'h304;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic        trc_valid = 0, trig_in = 0;
    logic [31:0] trc_data = '0;
    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    trace_ring_top u0 (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .trc_valid(trc_valid),
        .trc_data(trc_data), .trig_in(trig_in));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = v; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1;
        #1 v = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic push(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); trc_valid = 1; trc_data = base + i;
        end
        @(negedge clk); trc_valid = 0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1;
        @(negedge clk); trig_in = 0;
    endtask

    task automatic t_reset();
        expect_reg("R1 depth", SIZE, 32'd64);
        expect_reg("R1 status", STAT, 0);
        expect_reg("R1 fmt status", FSTS, 32'h2);
        expect_reg("R1 ctrl", CTRL, 0);
        expect_reg("R1 wptr", WPTR, 0);
        expect_reg("R1 rptr", RPTR, 0);
        expect_reg("R1 trg", TCNT, 0);
    endtask

    task automatic t_sw_access();
        wr(WDAT, 32'hA0); wr(WDAT, 32'hA1); wr(WDAT, 32'hA2);
        expect_reg("R2 wptr advance", WPTR, 3);
        wr(RPTR, 0);
        for (int i = 0; i < 3; i++) expect_reg("R2 readback", RDAT, 32'hA0 + i);
        expect_reg("R2 rptr advance", RPTR, 3);
        wr(WPTR, 63); wr(WDAT, 32'hBEEF);
        expect_reg("R2 wptr wrap", WPTR, 0);
        expect_reg("R5 full set", STAT, 1);
        wr(RPTR, 63);
        expect_reg("R2 read at top", RDAT, 32'hBEEF);
        expect_reg("R2 rptr wrap", RPTR, 0);
        wr(WPTR, 5);
        expect_reg("R5 full kept", STAT, 1);
        wr(WPTR, 0);
        expect_reg("R5 full cleared", STAT, 0);
    endtask

    task automatic t_trigger_stop();
        wr(WPTR, 0); wr(RPTR, 0); wr(TCNT, 5); wr(FCTL, 32'h2001); wr(CTRL, 1);
        expect_reg("R9 running", FSTS, 0);
        push(32'h100, 6);
        pulse_trig();
        push(32'h200, 10);
        repeat (4) @(negedge clk);
        expect_reg("R6 wptr after trigger", WPTR, 12);
        expect_reg("R6 count exhausted", TCNT, 0);
        expect_reg("R7 stopped", FSTS, 32'h2);
        wr(RPTR, 0);
        for (int i = 0; i < 6; i++) expect_reg("R4 pre-trigger word", RDAT, 32'h100 + i);
        for (int i = 0; i < 5; i++) expect_reg("R6 post-trigger word", RDAT, 32'h200 + i);
        expect_reg("R7 pad word", RDAT, 0);
    endtask

    task automatic t_no_trigger_and_disable();
        wr(WPTR, 0); wr(TCNT, 2); wr(FCTL, 32'h0001); wr(CTRL, 1);
        push(32'h300, 3);
        wr(WPTR, 40);
        expect_reg("R3 wptr write ignored", WPTR, 3);
        pulse_trig();
        push(32'h400, 4);
        expect_reg("R6 trigger ignored wptr", WPTR, 7);
        expect_reg("R6 trigger ignored state", FSTS, 0);
        expect_reg("R6 trigger ignored count", TCNT, 2);
        wr(CTRL, 0);
        repeat (3) @(negedge clk);
        expect_reg("R9 stopped by disable", FSTS, 32'h2);
        expect_reg("R9 padded wptr", WPTR, 8);
        wr(RPTR, 3);
        expect_reg("R3 data after ignored write", RDAT, 32'h400);
        wr(RPTR, 7);
        expect_reg("R7 pad zero", RDAT, 0);
    endtask

    task automatic t_flush();
        wr(WPTR, 0); wr(FCTL, 32'h0001); wr(CTRL, 1);
        push(32'h500, 2);
        wr(FCTL, 32'h0041);
        expect_reg("R8 flush busy", FCTL, 32'h0041);
        repeat (4) @(negedge clk);
        expect_reg("R8 flush cleared", FCTL, 32'h0001);
        expect_reg("R8 still running", FSTS, 0);
        expect_reg("R8 flush padded", WPTR, 4);
        push(32'h600, 1);
        expect_reg("R8 capture continues", WPTR, 5);
        wr(FCTL, 32'h1041);
        repeat (6) @(negedge clk);
        expect_reg("R8 stop on flush", FSTS, 32'h2);
        expect_reg("R8 stop padded", WPTR, 8);
        expect_reg("R8 bits after stop", FCTL, 32'h1001);
        push(32'h700, 3);
        expect_reg("R7 dropped while stopped", WPTR, 8);
    endtask

    task automatic t_wrap_capture();
        wr(WPTR, 60); wr(FCTL, 32'h0001); wr(CTRL, 1);
        push(32'h800, 6);
        expect_reg("R5 wrap sets full", STAT, 1);
        wr(CTRL, 0);
        repeat (4) @(negedge clk);
        expect_reg("R7 wrap padded", WPTR, 4);
        wr(RPTR, 63);
        expect_reg("R4 word at top", RDAT, 32'h803);
        expect_reg("R4 word at zero", RDAT, 32'h804);
        wr(WPTR, 0);
        expect_reg("R5 zero write clears", STAT, 0);
        wr(FCTL, 32'h3001);
        expect_reg("R10 fmt readback", FCTL, 32'h3001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_sw_access();
        t_trigger_stop();
        t_no_trigger_and_disable();
        t_flush();
        t_wrap_capture();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule